// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block tracks the power state of a small microcontroller and drives the enables that put it there. Software sets a deep-mode selector, a low-power-run request, a retention bit and a deep qualifier. A wait strobe from the core then starts entry into a sleep, stop, standby or shutdown state. Any asserted wake source brings the system back. Regulators and oscillators are not modelled as analog parts. Each is an enable output, and every regulator change holds its state for a parameterised number of cycles before it moves on.

The selector, request bits and wake sources are plain control levels. The block has no streaming data path, so no valid/ready handshake is used.

Several exit paths depend on the starting mode:
- Shallow sleep returns to the run state it came from.
- Stop 0 and Stop 1 resume in normal or low-power run, according to the request bit.
- Stop 2 always resumes in normal run.
- Standby and shutdown do not resume. They issue a restart pulse.

Leaving low-power run holds a regulator-low-power flag until the main regulator has settled. Only after that may fast clocks be permitted.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `pwr_state` is 0 (normal run). Both regulator enables are 1, `clk_en` is 4'b1111 and `fast_clk_ok` is 1. `reg_lp_flag`, `sram_ret` and `sys_reset_req` are 0. The `clk_en` bits are: bit0 core, bit1 peripherals, bit2 internal low-speed, bit3 external low-speed.
- R2: In run (0) with no wait strobe, `lpr_req`=1 moves to low-power run (1) on the next edge. Low-power run has main off, low-power regulator on, all clocks on, `reg_lp_flag`=1 and `fast_clk_ok`=0.
- R3: In low-power run, `lpr_req`=0 moves to the main-ready wait (2) for MAIN_RDY_CYC cycles. In that state main is on, `reg_lp_flag`=1 and `fast_clk_ok`=0. The next state is run, with the flag cleared and `fast_clk_ok`=1.
- R4: A wait strobe with `deep_en`=0 enters sleep (3) from run or low-power sleep (4) from low-power run. Both states have `clk_en`=4'b1110. Sleep keeps main on and low-power sleep turns it off. Any wake bit returns sleep to run and low-power sleep to low-power run on the next edge.
- R5: A wait strobe with `deep_en`=1 enters the entry-settle state (5) for ENTER_CYC cycles. That state shows the originating state's regulator and flag values. It then goes to the state chosen by `mode_sel`, sampled at the strobe: 0 is Stop 0 (6), 1 is Stop 1 (7), 2 is Stop 2 (8), 3 is standby (9), 4 is shutdown (10), and 5 to 7 are treated as Stop 0.
- R6: Every stop state has `clk_en`=4'b1100 and the low-power regulator on. Stop 0 keeps main on. Stop 1 and Stop 2 turn main off.
- R7: A wake in a stop state enters the exit-settle state (11). It stays there EXIT0_CYC cycles from Stop 0 or EXIT12_CYC cycles from Stop 1 or Stop 2. Stop 0 and Stop 1 then land in low-power run if `lpr_req` was 1 at the wake, or in run otherwise. Stop 2 always lands in run.
- R8: Standby uses `retain_en` sampled at the strobe. With the bit set, the low-power regulator is on and `sram_ret`=1. With it clear, both regulators are off and `sram_ret`=0. Main is off and `clk_en` is 4'b1100 in both cases.
- R9: Shutdown has both regulators off, `sram_ret`=0 and `clk_en`=4'b1000.
- R10: A wake in standby or shutdown enters the restart state (12) for RESTART_CYC cycles with `sys_reset_req`=1. The next state is run.
- R11: A wake during entry-settle aborts entry and returns to the originating run state on the next edge. This holds even on the last settle cycle.
- R12: The wait strobe has priority over `lpr_req` in run. In sleep states, neither the wait strobe nor `lpr_req` changes the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Deep mode selector |
| lpr_req | input | 1 | Low-power run request |
| retain_en | input | 1 | SRAM retention in standby |
| deep_en | input | 1 | Deep qualifier sampled with the wait strobe |
| wait_strobe | input | 1 | Wait-for-interrupt/event strobe |
| wake_src | input | NUM_WAKE | Wake sources, any bit wakes |
| main_reg_en | output | 1 | Main regulator enable |
| lp_reg_en | output | 1 | Low-power regulator enable |
| clk_en | output | 4 | Clock enables (core, periph, int LS, ext LS) |
| sram_ret | output | 1 | SRAM retention enable |
| reg_lp_flag | output | 1 | Regulator-in-low-power status |
| fast_clk_ok | output | 1 | Fast system clock permitted |
| sys_reset_req | output | 1 | Restart request |
| pwr_state | output | 4 | Current state code |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a wake source and the end of the entry-settle count. The bench raises a wake after each possible number of settle cycles, including the last one. It expects a return to the originating run state in every case and never the deep target.

The second pair is the wait strobe and a low-power-run request arriving together in run. The bench expects sleep to win.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [3:0] {
    ST_RUN      = 4'd0,
    ST_LPRUN    = 4'd1,
    ST_LPR_EXIT = 4'd2,
    ST_SLEEP    = 4'd3,
    ST_LPSLEEP  = 4'd4,
    ST_ENTER    = 4'd5,
    ST_STOP0    = 4'd6,
    ST_STOP1    = 4'd7,
    ST_STOP2    = 4'd8,
    ST_STANDBY  = 4'd9,
    ST_SHUTDOWN = 4'd10,
    ST_EXIT     = 4'd11,
    ST_RESTART  = 4'd12
  } pms_state_e;

  // clock domains, ordered from first gated to last gated
  localparam int CLK_W = 4;

  function automatic pms_state_e deep_target(input logic [2:0] sel);
    case (sel)
      3'd1:    return ST_STOP1;
      3'd2:    return ST_STOP2;
      3'd3:    return ST_STANDBY;
      3'd4:    return ST_SHUTDOWN;
      default: return ST_STOP0;
    endcase
  endfunction

  function automatic logic is_stop(input pms_state_e s);
    return (s == ST_STOP0) || (s == ST_STOP1) || (s == ST_STOP2);
  endfunction
endpackage

// File: rtl/pms_settle_timer.sv
module pms_settle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pms_out_decode.sv
module pms_out_decode
  import pms_pkg::*;
(
  input  pms_state_e       state,
  input  pms_state_e       origin,
  input  pms_state_e       exit_dest,
  input  logic             ret,
  output logic             main_reg_en,
  output logic             lp_reg_en,
  output logic [CLK_W-1:0] clk_en,
  output logic             sram_ret,
  output logic             reg_lp_flag,
  output logic             fast_clk_ok,
  output logic             sys_reset_req
);
  pms_state_e eff;
  logic [1:0] tier;   // 0 all on, 1 core gated, 2 low-speed only, 3 external low-speed only

  always_comb begin
    eff           = (state == ST_ENTER) ? origin : state;
    main_reg_en   = 1'b1;
    lp_reg_en     = 1'b1;
    sram_ret      = 1'b0;
    reg_lp_flag   = 1'b0;
    tier          = 2'd0;
    case (eff)
      ST_LPRUN, ST_LPR_EXIT: begin
        main_reg_en = (eff == ST_LPR_EXIT);
        reg_lp_flag = 1'b1;
      end
      ST_SLEEP:   tier = 2'd1;
      ST_LPSLEEP: begin
        tier = 2'd1; main_reg_en = 1'b0; reg_lp_flag = 1'b1;
      end
      ST_STOP0:   tier = 2'd2;
      ST_STOP1, ST_STOP2: begin
        tier = 2'd2; main_reg_en = 1'b0;
      end
      ST_STANDBY: begin
        tier = 2'd2; main_reg_en = 1'b0; lp_reg_en = ret; sram_ret = ret;
      end
      ST_SHUTDOWN: begin
        tier = 2'd3; main_reg_en = 1'b0; lp_reg_en = 1'b0;
      end
      ST_EXIT: begin
        tier = 2'd2; main_reg_en = (exit_dest == ST_RUN);
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < CLK_W; i++) begin : g_clk
    assign clk_en[i] = ({30'd0, tier} <= i);
  end

  assign fast_clk_ok   = (state == ST_RUN);
  assign sys_reset_req = (state == ST_RESTART);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NUM_WAKE     = 3,
  parameter int ENTER_CYC    = 4,
  parameter int EXIT0_CYC    = 3,
  parameter int EXIT12_CYC   = 8,
  parameter int MAIN_RDY_CYC = 5,
  parameter int RESTART_CYC  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode_sel,
  input  logic                lpr_req,
  input  logic                retain_en,
  input  logic                deep_en,
  input  logic                wait_strobe,
  input  logic [NUM_WAKE-1:0] wake_src,
  output logic                main_reg_en,
  output logic                lp_reg_en,
  output logic [CLK_W-1:0]    clk_en,
  output logic                sram_ret,
  output logic                reg_lp_flag,
  output logic                fast_clk_ok,
  output logic                sys_reset_req,
  output logic [3:0]          pwr_state
);
  localparam int MAX_A   = (ENTER_CYC > EXIT12_CYC) ? ENTER_CYC : EXIT12_CYC;
  localparam int MAX_B   = (MAIN_RDY_CYC > RESTART_CYC) ? MAIN_RDY_CYC : RESTART_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > EXIT0_CYC) ? MAX_C : EXIT0_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  pms_state_e       state_q, state_d, origin_q, target_q, dest_q;
  logic             ret_q;
  logic             wake_any, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  assign wake_any = |wake_src;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (wait_strobe)  state_d = deep_en ? ST_ENTER : ST_SLEEP;
        else if (lpr_req) state_d = ST_LPRUN;
      end
      ST_LPRUN: begin
        if (wait_strobe)   state_d = deep_en ? ST_ENTER : ST_LPSLEEP;
        else if (!lpr_req) state_d = ST_LPR_EXIT;
      end
      ST_LPR_EXIT: if (tmr_done) state_d = ST_RUN;
      ST_SLEEP:    if (wake_any) state_d = ST_RUN;
      ST_LPSLEEP:  if (wake_any) state_d = ST_LPRUN;
      ST_ENTER: begin
        if (wake_any)      state_d = origin_q;
        else if (tmr_done) state_d = target_q;
      end
      ST_STOP0, ST_STOP1, ST_STOP2: if (wake_any) state_d = ST_EXIT;
      ST_STANDBY, ST_SHUTDOWN:      if (wake_any) state_d = ST_RESTART;
      ST_EXIT:     if (tmr_done) state_d = dest_q;
      ST_RESTART:  if (tmr_done) state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_ENTER:    tmr_val = CNT_W'(ENTER_CYC - 1);
      ST_LPR_EXIT: tmr_val = CNT_W'(MAIN_RDY_CYC - 1);
      ST_RESTART:  tmr_val = CNT_W'(RESTART_CYC - 1);
      ST_EXIT:     tmr_val = (state_q == ST_STOP0) ? CNT_W'(EXIT0_CYC - 1)
                                                    : CNT_W'(EXIT12_CYC - 1);
      default: begin
        tmr_val  = '0;
        tmr_load = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      origin_q <= ST_RUN;
      target_q <= ST_STOP0;
      dest_q   <= ST_RUN;
      ret_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_ENTER && state_q != ST_ENTER) begin
        origin_q <= state_q;
        target_q <= deep_target(mode_sel);
        ret_q    <= retain_en;
      end
      if (is_stop(state_q) && state_d == ST_EXIT)
        dest_q <= (state_q != ST_STOP2 && lpr_req) ? ST_LPRUN : ST_RUN;
    end
  end

  pms_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  pms_out_decode u_dec (
    .state(state_q), .origin(origin_q), .exit_dest(dest_q), .ret(ret_q),
    .main_reg_en(main_reg_en), .lp_reg_en(lp_reg_en), .clk_en(clk_en),
    .sram_ret(sram_ret), .reg_lp_flag(reg_lp_flag), .fast_clk_ok(fast_clk_ok),
    .sys_reset_req(sys_reset_req)
  );

  assign pwr_state = state_q;
endmodule

// File: rtl/pms_checker.sv
module pms_checker
  import pms_pkg::*;
#(
  parameter int NUM_WAKE = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lpr_req,
  input logic                wait_strobe,
  input logic [NUM_WAKE-1:0] wake_src,
  input logic                main_reg_en,
  input logic                lp_reg_en,
  input logic [CLK_W-1:0]    clk_en,
  input logic                sram_ret,
  input logic                reg_lp_flag,
  input logic                fast_clk_ok,
  input logic                sys_reset_req,
  input logic [3:0]          pwr_state
);
  p_lpr_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_RUN && !wait_strobe && lpr_req) |=> pwr_state == ST_LPRUN);

  p_main_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_LPR_EXIT) |-> (reg_lp_flag && main_reg_en && !fast_clk_ok));

  p_fast_after_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_clk_ok) |-> !reg_lp_flag);

  p_stop_gating_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_STOP0 || pwr_state == ST_STOP1 || pwr_state == ST_STOP2)
      |-> (clk_en == 4'b1100 && lp_reg_en));

  p_shutdown_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_SHUTDOWN) |-> (!main_reg_en && !lp_reg_en && !sram_ret));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == ST_STANDBY || pwr_state == ST_SHUTDOWN) && |wake_src) |=> sys_reset_req);

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_ENTER && |wake_src) |=> (pwr_state == ST_RUN || pwr_state == ST_LPRUN));
endmodule

bind pwr_mode_seq pms_checker #(.NUM_WAKE(NUM_WAKE)) u_pms_chk (
  .clk(clk), .rst_n(rst_n), .lpr_req(lpr_req), .wait_strobe(wait_strobe),
  .wake_src(wake_src), .main_reg_en(main_reg_en), .lp_reg_en(lp_reg_en),
  .clk_en(clk_en), .sram_ret(sram_ret), .reg_lp_flag(reg_lp_flag),
  .fast_clk_ok(fast_clk_ok), .sys_reset_req(sys_reset_req), .pwr_state(pwr_state)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;
  localparam int NW = 3, ENT = 4, EX0 = 3, EX12 = 8, MRDY = 5, RST = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode_sel = '0;
  logic lpr_req = 0, retain_en = 0, deep_en = 0, wait_strobe = 0;
  logic [NW-1:0] wake_src = '0;
  logic main_reg_en, lp_reg_en, sram_ret, reg_lp_flag, fast_clk_ok, sys_reset_req;
  logic [3:0] clk_en, pwr_state;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.NUM_WAKE(NW), .ENTER_CYC(ENT), .EXIT0_CYC(EX0), .EXIT12_CYC(EX12),
                 .MAIN_RDY_CYC(MRDY), .RESTART_CYC(RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .lpr_req(lpr_req),
    .retain_en(retain_en), .deep_en(deep_en), .wait_strobe(wait_strobe),
    .wake_src(wake_src), .main_reg_en(main_reg_en), .lp_reg_en(lp_reg_en),
    .clk_en(clk_en), .sram_ret(sram_ret), .reg_lp_flag(reg_lp_flag),
    .fast_clk_ok(fast_clk_ok), .sys_reset_req(sys_reset_req), .pwr_state(pwr_state));

  // {main, lp, clk[3:0], ret, flag, fast, rst}
  function automatic logic [9:0] exp_vec(input int st, input logic ret);
    case (st)
      0:  return {1'b1, 1'b1, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0};
      1:  return {1'b0, 1'b1, 4'b1111, 1'b0, 1'b1, 1'b0, 1'b0};
      3:  return {1'b1, 1'b1, 4'b1110, 1'b0, 1'b0, 1'b0, 1'b0};
      4:  return {1'b0, 1'b1, 4'b1110, 1'b0, 1'b1, 1'b0, 1'b0};
      6:  return {1'b1, 1'b1, 4'b1100, 1'b0, 1'b0, 1'b0, 1'b0};
      7, 8: return {1'b0, 1'b1, 4'b1100, 1'b0, 1'b0, 1'b0, 1'b0};
      9:  return {1'b0, ret, 4'b1100, ret, 1'b0, 1'b0, 1'b0};
      10: return {1'b0, 1'b0, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0};
      default: return {1'b1, 1'b1, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b1};
    endcase
  endfunction

  function automatic logic [9:0] act_vec();
    return {main_reg_en, lp_reg_en, clk_en, sram_ret, reg_lp_flag, fast_clk_ok, sys_reset_req};
  endfunction

  function automatic int tgt(input int m);
    return (m >= 1 && m <= 4) ? 6 + m : 6;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 0; lpr_req = 0; retain_en = 0; deep_en = 0; wait_strobe = 0;
    wake_src = '0; mode_sel = '0;
    step(); rst_n = 1; step();
  endtask

  task automatic to_origin(input int orig);
    if (orig == 1) begin lpr_req = 1; step(); end
  endtask

  initial begin
    do_reset();
    chk("R1 state", 32'(pwr_state), 0);
    chk("R1 outputs", 32'(act_vec()), 32'(exp_vec(0, 0)));

    // low-power run entry and exit handshake
    lpr_req = 1; step();
    chk("R2 state", 32'(pwr_state), 1);
    chk("R2 outputs", 32'(act_vec()), 32'(exp_vec(1, 0)));
    lpr_req = 0; step();
    for (int i = 0; i < MRDY; i++) begin
      chk("R3 wait state", 32'(pwr_state), 2);
      chk("R3 flag/main/fast", {29'd0, reg_lp_flag, main_reg_en, fast_clk_ok}, 3'b110);
      if (i < MRDY - 1) step();
    end
    step();
    chk("R3 back to run", 32'(pwr_state), 0);
    chk("R3 run outputs", 32'(act_vec()), 32'(exp_vec(0, 0)));

    // strobe beats lpr_req
    do_reset();
    lpr_req = 1; wait_strobe = 1; step(); wait_strobe = 0; lpr_req = 0;
    chk("R12 strobe priority", 32'(pwr_state), 3);

    // sleep sweep over origins and wake bits
    for (int orig = 0; orig < 2; orig++) begin
      for (int w = 0; w < NW; w++) begin
        do_reset(); to_origin(orig);
        wait_strobe = 1; step(); wait_strobe = 0;
        chk("R4 sleep state", 32'(pwr_state), 32'(3 + orig));
        chk("R4 sleep outputs", 32'(act_vec()), 32'(exp_vec(3 + orig, 0)));
        wait_strobe = 1; deep_en = 1; lpr_req = ~lpr_req; step();
        wait_strobe = 0; deep_en = 0; lpr_req = (orig == 1);
        chk("R12 ignored in sleep", 32'(pwr_state), 32'(3 + orig));
        wake_src = NW'(1 << w); step(); wake_src = '0;
        chk("R4 wake return", 32'(pwr_state), 32'(orig));
      end
    end

    // deep sweep
    for (int orig = 0; orig < 2; orig++)
      for (int m = 0; m < 8; m++)
        for (int r = 0; r < 2; r++)
          for (int lw = 0; lw < 2; lw++) begin
            int t, d;
            do_reset(); to_origin(orig);
            t = tgt(m);
            mode_sel = 3'(m); retain_en = r[0]; deep_en = 1; wait_strobe = 1;
            step(); wait_strobe = 0; deep_en = 0; mode_sel = '0; retain_en = ~r[0];
            for (int i = 0; i < ENT; i++) begin
              chk("R5 entry settle", 32'(pwr_state), 5);
              chk("R5 origin main", 32'(main_reg_en), 32'(orig == 0));
              if (i < ENT - 1) step();
            end
            step();
            chk("R5 target", 32'(pwr_state), 32'(t));
            chk(t <= 8 ? "R6 stop outputs" : (t == 9 ? "R8 standby outputs" : "R9 shutdown outputs"),
                32'(act_vec()), 32'(exp_vec(t, r[0])));
            lpr_req = lw[0]; wake_src = 1; step(); wake_src = '0;
            if (t <= 8) begin
              d = (t == 8) ? 0 : lw;
              for (int i = 0; i < ((t == 6) ? EX0 : EX12); i++) begin
                chk("R7 exit settle", 32'(pwr_state), 11);
                if (i < ((t == 6) ? EX0 : EX12) - 1) step();
              end
              step();
              chk("R7 exit dest", 32'(pwr_state), 32'(d));
            end else begin
              for (int i = 0; i < RST; i++) begin
                chk("R10 restart", {28'd0, pwr_state}, 12);
                chk("R10 reset req", 32'(sys_reset_req), 1);
                if (i < RST - 1) step();
              end
              step();
              chk("R10 to run", 32'(pwr_state), 0);
            end
          end

    // abort at every settle cycle, including the last
    for (int orig = 0; orig < 2; orig++)
      for (int k = 1; k <= ENT; k++) begin
        do_reset(); to_origin(orig);
        mode_sel = 3'd1; deep_en = 1; wait_strobe = 1; step();
        wait_strobe = 0; deep_en = 0;
        repeat (k - 1) step();
        wake_src = 3'b100; step(); wake_src = '0;
        chk("R11 abort", 32'(pwr_state), 32'(orig));
      end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule